// File: doc/BRIEF.md
# Five-Level Haar Wavelet Denoiser

This block cleans one frame of signed integer samples at a time. A frame is collected into an internal coefficient array. Five Haar analysis passes are then run in the pyramid style: each pass splits the current approximation run into a half-length approximation part (sum of a pair) and a half-length detail part (difference of a pair). The detail bands of all five levels are then shrunk toward zero by a soft threshold. The coarsest approximation band is left as it is. Five synthesis passes rebuild a frame of the original length, and the result is streamed out one sample per cycle.

Each whole analysis or synthesis level runs in a single clock cycle across the full array, so the processing time does not depend on the data. A frame is opened by a start pulse. The threshold is captured on that pulse, so software can stage the next value while a frame is still loading. A start pulse that arrives while a frame is only partly loaded drops the partial frame, raises an error pulse and opens a new frame. A one-cycle done pulse marks the end of each output frame.

Top module: `haar_denoiser`

## Requirements
- R1: While idle and waiting for a frame, `in_ready` is high. A frame opens on a cycle where `frame_start` is high. A sample presented with `in_valid` on that same cycle is sample 0, and the next N-1 accepted samples follow in order. Samples presented with `in_valid` while no frame is open are dropped.
- R2: Analysis level k works on the first N/2^(k-1) array entries. It writes A[n] = X[2n] + X[2n+1] to the lower half and D[n] = X[2n] - X[2n+1] to the upper half. Entries beyond the active run keep their value, and no scaling is applied.
- R3: After five levels, every entry at index N/32 or above is a detail coefficient d and is replaced by sign(d)·max(|d| - T, 0). The N/32 entries below that index hold the final approximation and pass unchanged.
- R4: Synthesis runs from level 5 down to level 1. It produces X[2n] = (A[n] + D[n]) >>> 1 and X[2n+1] = (A[n] - D[n]) >>> 1, where >>> is an arithmetic (floor) shift, and restores the full frame length.
- R5: With T = 0 the output frame equals the input frame bit for bit, including at full-scale positive and negative values.
- R6: T is the unsigned value on `thr_in` in the cycle that opens the frame. Later changes to `thr_in` have no effect on that frame.
- R7: The first output sample is valid 12 clock cycles after the edge that accepts the last input sample. The N output samples then appear on N consecutive cycles in sample order.
- R8: `done` is high for exactly one cycle, in the cycle right after the last output sample, and `out_valid` is low in that cycle.
- R9: If `frame_start` arrives while a frame holds between 1 and N-1 samples, `frame_err` pulses for one cycle after that edge. The partial frame produces no output, and the new pulse opens a fresh frame.
- R10: From acceptance of the last sample until `done`, `in_ready` is low and `frame_start` and `in_valid` have no effect on the output frame.
- R11: After reset, `out_valid`, `done` and `frame_err` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Opens a frame and captures the threshold |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block accepts samples |
| in_data | input | IN_W | Signed input sample |
| thr_in | input | THR_W | Unsigned soft-threshold value |
| out_valid | output | 1 | Output sample valid |
| out_data | output | IN_W | Signed denoised sample |
| done | output | 1 | One-cycle pulse after the last output sample |
| frame_err | output | 1 | One-cycle pulse when a partial frame is dropped |

## Verification
The bench builds the block with its default values: N = 64 samples, 12-bit input and a 16-bit threshold. With these values the coarsest band holds two approximation and two level-5 detail entries, so every level and both band edges are exercised. The 12-bit width allows full-scale frames of -2048 and 2047, which push the 17-bit internal words to their largest sums. The 16-bit threshold allows a value large enough to clear every detail band, which leaves only 32-sample block averages in the output.

// File: rtl/haar_pkg.sv
// Package: shared constants and the sequencer state type for the Haar denoiser.
// Assumes a fixed five-level pyramid; frame length is checked at the top.
package haar_pkg;

    localparam int LEVELS = 5;

    typedef enum logic [2:0] {
        ST_LOAD   = 3'd0,
        ST_DECOMP = 3'd1,
        ST_SHRINK = 3'd2,
        ST_RECON  = 3'd3,
        ST_EMIT   = 3'd4,
        ST_DONE   = 3'd5
    } haar_state_t;

endpackage

// File: rtl/haar_ana_stage.sv
// Module: one Haar analysis level over the whole coefficient array.
// Pairs in the active run (N >> (LEVEL-1) entries) become sums in the lower
// half and differences in the upper half; entries above the run are copied.
// Assumes W is wide enough that no sum overflows (input width + LEVELS).
module haar_ana_stage #(
    parameter int N     = 64,
    parameter int W     = 17,
    parameter int LEVEL = 1
) (
    input  logic [N-1:0][W-1:0] din,
    output logic [N-1:0][W-1:0] dout
);
    localparam int RUN  = N >> (LEVEL - 1);
    localparam int HALF = RUN / 2;

    for (genvar i = 0; i < N; i++) begin : g_coef
        if (i < HALF) begin : g_sum
            // pair sum for the approximation half
            assign dout[i] = W'($signed(din[2*i]) + $signed(din[2*i+1]));
        end else if (i < RUN) begin : g_diff
            // pair difference for the detail half
            assign dout[i] = W'($signed(din[2*(i-HALF)]) - $signed(din[2*(i-HALF)+1]));
        end else begin : g_keep
            assign dout[i] = din[i];
        end
    end

endmodule

// File: rtl/haar_syn_stage.sv
// Module: one Haar synthesis level over the whole coefficient array.
// Lower-half entry n (approximation) and upper-half entry n (detail) of the
// active run are merged into samples 2n and 2n+1 with a floor halving.
// Assumes the array layout written by haar_ana_stage of the same LEVEL.
module haar_syn_stage #(
    parameter int N     = 64,
    parameter int W     = 17,
    parameter int LEVEL = 1
) (
    input  logic [N-1:0][W-1:0] din,
    output logic [N-1:0][W-1:0] dout
);
    localparam int RUN  = N >> (LEVEL - 1);
    localparam int HALF = RUN / 2;

    for (genvar i = 0; i < N; i++) begin : g_samp
        if (i < RUN) begin : g_merge
            logic [W:0] apx_x, det_x, mix;
            assign apx_x = {din[i/2][W-1], din[i/2]};
            assign det_x = {din[HALF + i/2][W-1], din[HALF + i/2]};
            // even output adds the detail, odd output subtracts it
            assign mix     = ((i % 2) == 0) ? (apx_x + det_x) : (apx_x - det_x);
            assign dout[i] = mix[W:1];
        end else begin : g_keep
            assign dout[i] = din[i];
        end
    end

endmodule

// File: rtl/haar_shrink.sv
// Module: soft threshold of one signed coefficient.
// Output is sign(c) * max(|c| - thr, 0); the magnitude never grows.
// Assumes thr is unsigned; works in a widened word so |c| never overflows.
module haar_shrink #(
    parameter int W     = 17,
    parameter int THR_W = 16
) (
    input  logic [W-1:0]     coef,
    input  logic [THR_W-1:0] thr,
    output logic [W-1:0]     res
);
    localparam int CW = ((W > THR_W) ? W : THR_W) + 1;

    logic signed [CW-1:0] c_x, t_x, mag, red;

    // shrink toward zero by thr, clamp at zero
    always_comb begin
        c_x = {{(CW-W){coef[W-1]}}, coef};
        t_x = {{(CW-THR_W){1'b0}}, thr};
        mag = c_x[CW-1] ? -c_x : c_x;
        if (mag <= t_x) begin
            red = '0;
        end else if (c_x[CW-1]) begin
            red = c_x + t_x;
        end else begin
            red = c_x - t_x;
        end
        res = red[W-1:0];
    end

endmodule

// File: rtl/haar_seq.sv
// Module: frame sequencer for the Haar denoiser.
// Walks load, five analysis steps, shrink, five synthesis steps, emit, done.
// Assumes N >= 32; indices are log2(N) bits wide.
module haar_seq
    import haar_pkg::*;
#(
    parameter int N  = 64,
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          in_valid,
    output logic          in_ready,
    output logic          load_en,
    output logic          thr_load,
    output logic [IW-1:0] wr_idx,
    output logic          step_ana,
    output logic          step_shr,
    output logic          step_syn,
    output logic [2:0]    lvl,
    output logic          emit_en,
    output logic [IW-1:0] rd_idx,
    output logic          out_valid,
    output logic          done,
    output logic          frame_err
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    haar_state_t   state;
    logic          open_q;
    logic [IW-1:0] cnt;

    // handshake and datapath strobes decoded from the state
    always_comb begin
        in_ready = (state == ST_LOAD);
        thr_load = in_ready && frame_start;
        load_en  = in_ready && in_valid && (open_q || frame_start);
        wr_idx   = frame_start ? '0 : cnt;
        step_ana = (state == ST_DECOMP);
        step_shr = (state == ST_SHRINK);
        step_syn = (state == ST_RECON);
        emit_en  = (state == ST_EMIT);
        rd_idx   = cnt;
    end

    // phase sequencing, sample counting and status pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_LOAD;
            open_q    <= 1'b0;
            cnt       <= '0;
            lvl       <= '0;
            out_valid <= 1'b0;
            done      <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            done      <= 1'b0;
            frame_err <= 1'b0;
            case (state)
                ST_LOAD: begin
                    if (frame_start) begin
                        open_q    <= 1'b1;
                        frame_err <= open_q && (cnt != '0);
                        cnt       <= load_en ? IW'(1) : '0;
                    end else if (load_en) begin
                        if (cnt == LAST) begin
                            state  <= ST_DECOMP;
                            lvl    <= 3'd1;
                            open_q <= 1'b0;
                            cnt    <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_DECOMP: begin
                    if (lvl == 3'(LEVELS)) begin
                        state <= ST_SHRINK;
                    end else begin
                        lvl <= lvl + 1'b1;
                    end
                end
                ST_SHRINK: begin
                    state <= ST_RECON;
                    lvl   <= 3'(LEVELS);
                end
                ST_RECON: begin
                    if (lvl == 3'd1) begin
                        state <= ST_EMIT;
                        cnt   <= '0;
                    end else begin
                        lvl <= lvl - 1'b1;
                    end
                end
                ST_EMIT: begin
                    out_valid <= 1'b1;
                    if (cnt == LAST) begin
                        state <= ST_DONE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DONE: begin
                    done  <= 1'b1;
                    state <= ST_LOAD;
                end
                default: state <= ST_LOAD;
            endcase
        end
    end

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!out_valid && $past(out_valid)));
    p_err_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> !out_valid);
    p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    p_level_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ana || step_syn) |-> (lvl >= 3'd1 && lvl <= 3'(LEVELS)));

endmodule

// File: rtl/haar_denoiser.sv
// Module: top of the five-level Haar wavelet denoiser.
// Holds the coefficient array and applies, one per cycle, the analysis level,
// soft shrink or synthesis level picked by the sequencer, then streams out.
// Assumes N is a multiple of 32; internal words are IN_W + 5 bits wide.
module haar_denoiser
    import haar_pkg::*;
#(
    parameter int N     = 64,
    parameter int IN_W  = 12,
    parameter int THR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IN_W-1:0]  in_data,
    input  logic [THR_W-1:0] thr_in,
    output logic             out_valid,
    output logic [IN_W-1:0]  out_data,
    output logic             done,
    output logic             frame_err
);
    localparam int W      = IN_W + LEVELS;
    localparam int IW     = $clog2(N);
    localparam int APX_N  = N >> LEVELS;

    initial begin
        if ((N % (1 << LEVELS)) != 0) $error("frame length must be a multiple of 32");
    end

    logic [N-1:0][W-1:0] coef_q;
    logic [N-1:0][W-1:0] ana_o [LEVELS];
    logic [N-1:0][W-1:0] syn_o [LEVELS];
    logic [N-1:0][W-1:0] shr_o;
    logic [THR_W-1:0]    thr_q;
    logic [IN_W-1:0]     out_q;

    logic          load_en, thr_load, step_ana, step_shr, step_syn, emit_en;
    logic [IW-1:0] wr_idx, rd_idx;
    logic [2:0]    lvl, lvl_ix;

    haar_seq #(.N(N), .IW(IW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .load_en    (load_en),
        .thr_load   (thr_load),
        .wr_idx     (wr_idx),
        .step_ana   (step_ana),
        .step_shr   (step_shr),
        .step_syn   (step_syn),
        .lvl        (lvl),
        .emit_en    (emit_en),
        .rd_idx     (rd_idx),
        .out_valid  (out_valid),
        .done       (done),
        .frame_err  (frame_err)
    );

    for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
        haar_ana_stage #(.N(N), .W(W), .LEVEL(k + 1)) u_ana (
            .din (coef_q),
            .dout(ana_o[k])
        );
        haar_syn_stage #(.N(N), .W(W), .LEVEL(k + 1)) u_syn (
            .din (coef_q),
            .dout(syn_o[k])
        );
    end

    for (genvar i = 0; i < N; i++) begin : g_band
        if (i < APX_N) begin : g_apx
            assign shr_o[i] = coef_q[i];
        end else begin : g_det
            haar_shrink #(.W(W), .THR_W(THR_W)) u_shr (
                .coef(coef_q[i]),
                .thr (thr_q),
                .res (shr_o[i])
            );
        end
    end

    assign lvl_ix = lvl - 3'd1;

    // threshold capture on the frame-opening cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= '0;
        end else if (thr_load) begin
            thr_q <= thr_in;
        end
    end

    // coefficient array: load, then one transform step per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coef_q <= '0;
        end else if (load_en) begin
            coef_q[wr_idx] <= {{LEVELS{in_data[IN_W-1]}}, in_data};
        end else if (step_ana) begin
            coef_q <= ana_o[lvl_ix];
        end else if (step_shr) begin
            coef_q <= shr_o;
        end else if (step_syn) begin
            coef_q <= syn_o[lvl_ix];
        end
    end

    // output sample register, low bits of the rebuilt sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (emit_en) begin
            out_q <= coef_q[rd_idx][IN_W-1:0];
        end
    end

    assign out_data = out_q;

    p_apx_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step_shr |=> (coef_q[0] == $past(coef_q[0])));
    p_thr_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !thr_load |=> $stable(thr_q));
    p_busy_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        emit_en |=> $stable(coef_q));

endmodule

// File: tb/haar_denoiser_tb.sv
`timescale 1ns/1ps
module haar_denoiser_tb;
    localparam int N     = 64;
    localparam int IN_W  = 12;
    localparam int THR_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_start = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [IN_W-1:0]  in_data = '0;
    logic [THR_W-1:0] thr_in = '0;
    logic             out_valid;
    logic [IN_W-1:0]  out_data;
    logic             done;
    logic             frame_err;

    int n_chk = 0;
    int n_fail = 0;
    int frame_in [N];
    int exp_out  [N];
    int wa [N];
    int wt [N];

    always #2 clk = ~clk;

    haar_denoiser #(.N(N), .IN_W(IN_W), .THR_W(THR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .thr_in(thr_in), .out_valid(out_valid), .out_data(out_data),
        .done(done), .frame_err(frame_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int rnd_sample();
        return int'($urandom_range(4095)) - 2048;
    endfunction

    // reference: five analysis levels, soft shrink of details, five synthesis levels
    task automatic compute_expected(input int t);
        int run;
        for (int i = 0; i < N; i++) wa[i] = frame_in[i];
        for (int k = 1; k <= 5; k++) begin
            run = N >> (k - 1);
            for (int n = 0; n < run / 2; n++) begin
                wt[n]           = wa[2*n] + wa[2*n+1];
                wt[run / 2 + n] = wa[2*n] - wa[2*n+1];
            end
            for (int i = 0; i < run; i++) wa[i] = wt[i];
        end
        for (int i = N / 32; i < N; i++) begin
            if (wa[i] > t) wa[i] = wa[i] - t;
            else if (wa[i] < -t) wa[i] = wa[i] + t;
            else wa[i] = 0;
        end
        for (int k = 5; k >= 1; k--) begin
            run = N >> (k - 1);
            for (int n = 0; n < run / 2; n++) begin
                wt[2*n]   = (wa[n] + wa[run / 2 + n]) >>> 1;
                wt[2*n+1] = (wa[n] - wa[run / 2 + n]) >>> 1;
            end
            for (int i = 0; i < run; i++) wa[i] = wt[i];
        end
        for (int i = 0; i < N; i++) exp_out[i] = wa[i];
    endtask

    // load frame_in, then check latency, samples, done; noise driven while busy
    task automatic run_frame(input int t, input bit exp_err, input bit use_model);
        int first_k;
        if (use_model) compute_expected(t);
        else for (int i = 0; i < N; i++) exp_out[i] = frame_in[i];
        repeat (3) begin
            @(negedge clk);
            frame_start = 1'b0;
            in_valid = 1'b1;
            in_data = IN_W'(rnd_sample());
        end
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            if (i == 1) check(frame_err == exp_err, "R9", "frame_err pulse", int'(frame_err), int'(exp_err));
            if (i == 2) check(frame_err == 1'b0, "R9", "frame_err one cycle", int'(frame_err), 0);
            if (i > 0 && out_valid) check(1'b0, "R9", "output while loading", 1, 0);
            frame_start = (i == 0);
            in_valid = 1'b1;
            in_data = IN_W'(frame_in[i]);
            thr_in = (i == 0) ? THR_W'(t) : THR_W'($urandom_range(65535));
        end
        first_k = -1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            frame_start = 1'b1;
            in_valid = 1'b1;
            in_data = IN_W'(rnd_sample());
            if (!in_ready) n_chk = n_chk;
            else check(1'b0, "R10", "in_ready while busy", 1, 0);
            if (out_valid) begin
                first_k = k;
                break;
            end
        end
        check(first_k == 12, "R7", "first output latency", first_k, 12);
        for (int j = 0; j < N; j++) begin
            if (j > 0) @(negedge clk);
            if (j == N - 1) begin
                frame_start = 1'b0;
                in_valid = 1'b0;
            end
            check(out_valid == 1'b1, "R7", "contiguous out_valid", int'(out_valid), 1);
            check(done == 1'b0, "R8", "done early", int'(done), 0);
            check($signed(out_data) == exp_out[j], use_model ? "R3/R4" : "R5",
                  $sformatf("sample %0d", j), int'($signed(out_data)), exp_out[j]);
        end
        @(negedge clk);
        check(done == 1'b1, "R8", "done after last", int'(done), 1);
        check(out_valid == 1'b0, "R8", "out_valid low at done", int'(out_valid), 0);
        @(negedge clk);
        check(done == 1'b0, "R8", "done single cycle", int'(done), 0);
        check(in_ready == 1'b1, "R1", "ready after frame", int'(in_ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(out_valid == 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);
        check(done == 1'b0, "R11", "done after reset", int'(done), 0);
        check(frame_err == 1'b0, "R11", "frame_err after reset", int'(frame_err), 0);
        check(in_ready == 1'b1, "R11", "in_ready after reset", int'(in_ready), 1);

        // R5 identity with zero threshold, random frames
        for (int f = 0; f < 3; f++) begin
            for (int i = 0; i < N; i++) frame_in[i] = rnd_sample();
            run_frame(0, 1'b0, 1'b0);
        end
        // R5 identity at full scale
        for (int i = 0; i < N; i++) frame_in[i] = 2047;
        run_frame(0, 1'b0, 1'b0);
        for (int i = 0; i < N; i++) frame_in[i] = -2048;
        run_frame(0, 1'b0, 1'b0);
        for (int i = 0; i < N; i++) frame_in[i] = (i % 2 == 0) ? 2047 : -2048;
        run_frame(0, 1'b0, 1'b0);

        // R2 R3 R4 random threshold, random frames
        for (int f = 0; f < 4; f++) begin
            for (int i = 0; i < N; i++) frame_in[i] = rnd_sample();
            run_frame(int'($urandom_range(300, 1)), 1'b0, 1'b1);
        end
        // R3 threshold clears all details: block averages remain
        for (int i = 0; i < N; i++) frame_in[i] = rnd_sample();
        run_frame(65535, 1'b0, 1'b1);
        // R3 constant frame: approximation band kept, output unchanged
        for (int i = 0; i < N; i++) frame_in[i] = -777;
        run_frame(500, 1'b0, 1'b0);

        // R9 partial frame dropped, then a full frame with threshold (R6 via garbage thr_in)
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            frame_start = (i == 0);
            in_valid = 1'b1;
            in_data = IN_W'(rnd_sample());
            thr_in = THR_W'($urandom_range(65535));
        end
        for (int i = 0; i < N; i++) frame_in[i] = rnd_sample();
        run_frame(40, 1'b1, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule